// File: doc/BRIEF.md
# Glitch-free clock source selector

This block is one output slice of a clock control unit. It picks one of four incoming clocks with a two-bit code, gates it with an enable bit, and drives the result to a pad and to an internal consumer. A change of source, or a change of the enable, always passes through a closed window. The old clock is shut on its own falling edge. Only after that is the new clock opened, on its own falling edge. Neither output ever shows a shortened high or low phase.

Software talks to the slice through a single 32-bit control word: `wr_en` with `wr_data` writes it, and `rd_data` always shows it. A read-only busy bit reports, in the register clock domain, that the output is held off while a switch is in progress. Two output options are also provided. One inverts only the copy that goes to the internal consumer. The other replaces the internal copy with the clock that comes back from the pad, gated by the enable.

Top module: `glitchfree_clk_sel`

## Requirements
- R1: After reset, `rd_data` reads 0x0000_0001: bit 0 (enable) is 1, bits 2:1 (select) are 00, and bit 8 (busy) is 0. Source 0 drives `clk_pad` with no switch sequence.
- R2: Select code 00 passes `src_clk[0]`, 01 passes `src_clk[1]`, and 11 passes `src_clk[3]`. Code 10 passes `src_clk[0]` when `CODE2_IS_REF` is 1 (the default), and `src_clk[2]` otherwise. The period of `clk_pad` equals the period of the chosen source.
- R3: Bits 31:9 and 5:3 of `rd_data` read 0 whatever was written to them.
- R4: Take a write, with bit 0 set, that moves the output from one effective source to another while the slice is settled. Busy (bit 8) then reads 1 from the second register clock edge after that write. It stays 1 until the new source passes, and then returns to 0.
- R5: A write that repeats the current enable and select bits leaves busy at 0.
- R6: Clearing bit 0 stops `clk_pad` in the low state. Busy then returns to 0 and no further edges appear. Setting bit 0 again restarts the selected clock at its own period.
- R7: Across all switches and enable changes, no high or low phase of `clk_pad` is shorter than half the period of the fastest source. At most one source gate is open at any time.
- R8: Bit 7 set inverts `clk_int` only; `clk_pad` keeps its polarity.
- R9: With bit 6 set, `clk_int` follows `pad_fb_clk` (the returned pad clock), gated by the enable, instead of the internal copy.
- R10: Bit 8 is read-only: writing 1 to it has no effect on the value read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register port clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| wr_en | input | 1 | Writes `wr_data` into the control word on the next `reg_clk` rising edge |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word with busy at bit 8 |
| src_clk | input | 4 | Candidate source clocks, index equals select code (code 10 may alias 00) |
| pad_fb_clk | input | 1 | Clock returned from the pad, used in feedback mode |
| clk_pad | output | 1 | Selected and gated clock towards the pad |
| clk_int | output | 1 | Clock towards the internal consumer |

## Verification
Suppose a source gate is stuck open, or closes without the switch sequence. That would show within one period of the slower source as a wrong `clk_pad` period, or as a short high or low phase. The bench times every edge to catch this. Suppose instead the busy flag loses track of the gate state. It then either stays at 1, so the busy wait times out within a few hundred register cycles, or never rises, which the read on the second edge after the switching write catches. A wrong output-option path shows at once, at the next pad rising edge, as a wrong level of `clk_int` a few nanoseconds later.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int SEL_W    = 2;
    localparam int NUM_SRC  = 1 << SEL_W;
    localparam int WORD_W   = 32;
    // control word field positions
    localparam int EN_BIT   = 0;
    localparam int SEL_LSB  = 1;
    localparam int MODE_BIT = 6;
    localparam int INV_BIT  = 7;
    localparam int ACK_BIT  = 8;

    typedef struct packed {
        logic             inv;
        logic             fb_mode;
        logic [SEL_W-1:0] sel;
        logic             en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{inv: 1'b0, fb_mode: 1'b0, sel: '0, en: 1'b1};

    // source index a select code stands for
    function automatic logic [SEL_W-1:0] src_of(input logic [SEL_W-1:0] code,
                                                input logic               code2_ref);
        src_of = (code2_ref && code == SEL_W'(2)) ? '0 : code;
    endfunction

    function automatic logic [NUM_SRC-1:0] onehot_of(input logic [SEL_W-1:0] idx);
        onehot_of = NUM_SRC'(1) << idx;
    endfunction
endpackage

// File: rtl/csel_gate_cell.sv
// One gate: a request synchronised on the falling edge of its own clock.
module csel_gate_cell #(
    parameter int STAGES     = 2,
    parameter bit START_OPEN = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic block_i,
    output logic gate_o,
    output logic clk_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } cell_t;

    cell_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.chain = {c_q.chain[STAGES-2:0], req_i & ~block_i};
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q.chain <= {STAGES{START_OPEN}};
        end else begin
            c_q <= c_d;
        end
    end

    assign gate_o = c_q.chain[STAGES-1];
    assign clk_o  = clk_i & gate_o;
endmodule

// File: rtl/csel_ctrl_regs.sv
// Control word, gate-status synchroniser and busy flag in the register domain.
module csel_ctrl_regs
    import csel_pkg::*;
#(
    parameter bit CODE2_IS_REF = 1'b1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    input  logic [NUM_SRC-1:0] gate_status_i,
    output logic [NUM_SRC-1:0] req_o,
    output ctrl_t              ctrl_o,
    output logic [WORD_W-1:0]  rd_data_o
);
    typedef struct packed {
        ctrl_t                                ctrl;
        logic [SYNC_STAGES-1:0][NUM_SRC-1:0] sync;
        logic                                 ack;
    } state_t;

    state_t s_d, s_q;
    logic [NUM_SRC-1:0] want;

    assign want = s_q.ctrl.en ? onehot_of(src_of(s_q.ctrl.sel, CODE2_IS_REF)) : '0;

    always_comb begin
        s_d = s_q;
        if (wr_en_i) begin
            s_d.ctrl.en      = wr_data_i[EN_BIT];
            s_d.ctrl.sel     = wr_data_i[SEL_LSB +: SEL_W];
            s_d.ctrl.fb_mode = wr_data_i[MODE_BIT];
            s_d.ctrl.inv     = wr_data_i[INV_BIT];
        end
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], gate_status_i};
        s_d.ack  = (s_q.sync[SYNC_STAGES-1] != want);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.ctrl <= CTRL_RST;
            s_q.sync <= {SYNC_STAGES{NUM_SRC'(1)}};
            s_q.ack  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data_o                      = '0;
        rd_data_o[EN_BIT]              = s_q.ctrl.en;
        rd_data_o[SEL_LSB +: SEL_W]    = s_q.ctrl.sel;
        rd_data_o[MODE_BIT]            = s_q.ctrl.fb_mode;
        rd_data_o[INV_BIT]             = s_q.ctrl.inv;
        rd_data_o[ACK_BIT]             = s_q.ack;
    end

    logic unused_wr;
    assign unused_wr = ^{wr_data_i[WORD_W-1:ACK_BIT], wr_data_i[MODE_BIT-1:SEL_LSB+SEL_W]};

    assign req_o  = want;
    assign ctrl_o = s_q.ctrl;
endmodule

// File: rtl/glitchfree_clk_sel.sv
module glitchfree_clk_sel
    import csel_pkg::*;
#(
    parameter bit CODE2_IS_REF = 1'b1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               reg_clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wr_data,
    output logic [WORD_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic               pad_fb_clk,
    output logic               clk_pad,
    output logic               clk_int
);
    logic [NUM_SRC-1:0] src_req;
    logic [NUM_SRC-1:0] src_gate;
    logic [NUM_SRC-1:0] src_gated;
    ctrl_t              ctrl;
    logic               mux_clk;
    logic               fb_gated;
    logic               unused_fb_gate;

    csel_ctrl_regs #(
        .CODE2_IS_REF (CODE2_IS_REF),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_regs (
        .clk_i         (reg_clk),
        .rst_ni        (rst_n),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .gate_status_i (src_gate),
        .req_o         (src_req),
        .ctrl_o        (ctrl),
        .rd_data_o     (rd_data)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic others_open;
        assign others_open = |(src_gate & ~(NUM_SRC'(1) << i));

        csel_gate_cell #(
            .STAGES     (SYNC_STAGES),
            .START_OPEN (i == 0)
        ) u_cell (
            .clk_i   (src_clk[i]),
            .rst_ni  (rst_n),
            .req_i   (src_req[i]),
            .block_i (others_open),
            .gate_o  (src_gate[i]),
            .clk_o   (src_gated[i])
        );
    end

    assign mux_clk = |src_gated;

    // returned pad clock, gated by the enable on its own falling edge
    csel_gate_cell #(
        .STAGES     (SYNC_STAGES),
        .START_OPEN (1'b1)
    ) u_fb_cell (
        .clk_i   (pad_fb_clk),
        .rst_ni  (rst_n),
        .req_i   (ctrl.en),
        .block_i (1'b0),
        .gate_o  (unused_fb_gate),
        .clk_o   (fb_gated)
    );

    assign clk_pad = mux_clk;
    assign clk_int = (ctrl.fb_mode ? fb_gated : mux_clk) ^ ctrl.inv;
endmodule

// File: rtl/glitchfree_clk_sel_chk.sv
module glitchfree_clk_sel_chk
    import csel_pkg::*;
#(
    parameter bit CODE2_IS_REF = 1'b1
) (
    input logic               reg_clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [SEL_W:0]     wr_ctrl,
    input logic [SEL_W:0]     rd_ctrl,
    input logic               rd_ack,
    input logic               clk_pad,
    input logic [NUM_SRC-1:0] src_gate
);
    logic [SEL_W:0] prev_q;
    logic           prev_ok_q;
    logic           settled;

    always_ff @(posedge reg_clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= '0;
            prev_ok_q <= 1'b0;
        end else begin
            prev_q    <= rd_ctrl;
            prev_ok_q <= 1'b1;
        end
    end

    assign settled = prev_ok_q && (prev_q == rd_ctrl) && !rd_ack;

    // R4
    ack_rise_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        (settled && wr_en && wr_ctrl[0] && rd_ctrl[0] &&
         src_of(wr_ctrl[SEL_W:1], CODE2_IS_REF) != src_of(rd_ctrl[SEL_W:1], CODE2_IS_REF))
        |-> ##2 rd_ack);

    // R5
    same_sel_quiet_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        (settled && wr_en && wr_ctrl == rd_ctrl) |=> !rd_ack);

    // R6
    stopped_low_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        (settled && !rd_ctrl[0]) |-> !clk_pad);

    // R7
    one_gate_chk: assert property (@(posedge reg_clk) disable iff (!rst_n)
        $onehot0(src_gate));
endmodule

bind glitchfree_clk_sel glitchfree_clk_sel_chk #(.CODE2_IS_REF(CODE2_IS_REF)) u_chk (
    .reg_clk  (reg_clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_ctrl  (wr_data[csel_pkg::SEL_W:0]),
    .rd_ctrl  (rd_data[csel_pkg::SEL_W:0]),
    .rd_ack   (rd_data[csel_pkg::ACK_BIT]),
    .clk_pad  (clk_pad),
    .src_gate (src_gate)
);

// File: tb/glitchfree_clk_sel_test.sv
`timescale 1ns/1ps
module glitchfree_clk_sel_test;
    logic        reg_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        wr_en   = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
    logic [3:0]  src_clk;
    logic        pad_fb_clk = 1'b0;
    logic        clk_pad, clk_int;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // 50 MHz register clock; sources 40, 24, 60, 32 ns
    always #10 reg_clk = ~reg_clk;
    always #20 s0 = ~s0;
    always #12 s1 = ~s1;
    always #30 s2 = ~s2;
    always #16 s3 = ~s3;
    assign src_clk = {s3, s2, s1, s0};
    always @(clk_pad) pad_fb_clk <= #3 clk_pad;

    glitchfree_clk_sel uut (
        .reg_clk    (reg_clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .src_clk    (src_clk),
        .pad_fb_clk (pad_fb_clk),
        .clk_pad    (clk_pad),
        .clk_int    (clk_int)
    );

    // phase-width monitor for R7
    realtime last_edge = 0.0;
    int      runt_cnt  = 0;
    int      pad_rises = 0;
    bit      armed     = 1'b0;
    always @(clk_pad) begin
        if (armed && ($realtime - last_edge) < 11.5) runt_cnt++;
        last_edge = $realtime;
    end
    always @(posedge clk_pad) pad_rises++;

    // scoreboard for register reads
    typedef struct {
        logic [31:0] val;
        logic [31:0] mask;
        string       req;
    } exp_t;
    exp_t sb_q[$];
    exp_t mon_e;

    initial forever begin
        @(negedge reg_clk);
        if (sb_q.size() != 0) begin
            mon_e = sb_q.pop_front();
            n_checks++;
            if ((rd_data & mon_e.mask) !== (mon_e.val & mon_e.mask)) begin
                n_fails++;
                $display("FAIL %s register read: actual %h expected %h",
                         mon_e.req, rd_data & mon_e.mask, mon_e.val & mon_e.mask);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_reg(input logic [31:0] v, input logic [31:0] m, input string r);
        exp_t e;
        @(posedge reg_clk);
        #2;
        e.val  = v;
        e.mask = m;
        e.req  = r;
        sb_q.push_back(e);
        @(negedge reg_clk);
        #1;
    endtask

    task automatic do_write(input logic [31:0] v);
        @(negedge reg_clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge reg_clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic wait_ack(input string req);
        int n;
        n = 0;
        repeat (3) @(negedge reg_clk);
        while (rd_data[8] !== 1'b0 && n < 400) begin
            @(negedge reg_clk);
            n++;
        end
        chk(n < 400, req, "busy clears, cycles", n, 400);
    endtask

    task automatic measure(input real exp, input string req);
        realtime t0, t1;
        @(posedge clk_pad);
        t0 = $realtime;
        @(posedge clk_pad);
        t1 = $realtime;
        chk(((t1 - t0) > exp - 0.5) && ((t1 - t0) < exp + 0.5), req, "pad period ps",
            longint'((t1 - t0) * 1000.0), longint'(exp * 1000.0));
    endtask

    int hits;
    int rises_before;

    initial begin
        repeat (5) @(negedge reg_clk);
        rst_n = 1'b1;
        repeat (2) @(negedge reg_clk);
        armed = 1'b1;

        // R1: reset word and source 0 running
        expect_reg(32'h0000_0001, '1, "R1");
        measure(40.0, "R1");

        // R4: switch to code 01, busy on second edge, then clears
        do_write(32'h0000_0003);
        expect_reg(32'h0000_0103, '1, "R4");
        wait_ack("R4");
        expect_reg(32'h0000_0003, '1, "R4");
        measure(24.0, "R2 code 01");

        // R5: repeat of the same value never raises busy
        do_write(32'h0000_0003);
        hits = 0;
        repeat (20) begin
            @(negedge reg_clk);
            if (rd_data[8] !== 1'b0) hits++;
        end
        chk(hits == 0, "R5", "busy cycles after same write", hits, 0);

        // R2: code 11 and aliased code 10
        do_write(32'h0000_0007);
        wait_ack("R2");
        measure(32.0, "R2 code 11");
        do_write(32'h0000_0005);
        wait_ack("R2");
        measure(40.0, "R2 code 10");

        // R3: reserved bits read zero
        do_write(32'hFFFF_FE3B);
        expect_reg(32'h0000_0003, 32'hFFFF_FEFF, "R3");
        wait_ack("R3");

        // R10: busy bit cannot be written
        do_write(32'h0000_0103);
        expect_reg(32'h0000_0003, '1, "R10");

        // R6: disable stops low, then restart
        do_write(32'h0000_0002);
        wait_ack("R6");
        expect_reg(32'h0000_0002, '1, "R6");
        rises_before = pad_rises;
        #400;
        chk(pad_rises == rises_before, "R6", "pad rises while disabled", pad_rises - rises_before, 0);
        chk(clk_pad === 1'b0, "R6", "pad level while disabled", clk_pad, 0);
        do_write(32'h0000_0003);
        wait_ack("R6");
        measure(24.0, "R6");

        // R8: inversion only towards the internal consumer
        do_write(32'h0000_0083);
        repeat (3) @(negedge reg_clk);
        @(posedge clk_pad);
        #2;
        chk(clk_int === 1'b0, "R8", "internal level after pad rise", clk_int, 0);
        chk(clk_pad === 1'b1, "R8", "pad level after pad rise", clk_pad, 1);

        // R9: feedback mode follows the returned clock
        do_write(32'h0000_0043);
        repeat (3) @(negedge reg_clk);
        @(posedge clk_pad);
        #1;
        chk(clk_int === 1'b0, "R9", "internal level before return", clk_int, 0);
        #3;
        chk(clk_int === 1'b1, "R9", "internal level after return", clk_int, 1);

        // R8 in feedback mode
        do_write(32'h0000_00C3);
        repeat (3) @(negedge reg_clk);
        @(posedge clk_pad);
        #5;
        chk(clk_int === 1'b0, "R8", "inverted returned clock", clk_int, 0);

        do_write(32'h0000_0003);
        wait_ack("R1");
        chk(runt_cnt == 0, "R7", "short pad phases", runt_cnt, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule